// File: doc/BRIEF.md
# Coefficient and Configuration Byte Port

This block is the host-side loading port of a decimating filter engine. A host reaches it through an 8-bit data bus with a 3-bit register address and separate write and read strobes. Seven addresses hold configuration bytes. The block decodes the fields of those bytes and drives them straight to the filter. The remaining address is a window into a bank of wide coefficient words.

A coefficient is built from consecutive byte writes to the window address, least significant byte first. The first bytes wait in a holding register. The final byte completes the word, and the whole word is stored at the entry named by an internal pointer. The pointer then steps to the next entry. A mode bit in the control register selects the direction of the window. In read mode the host pulls the stored words back out byte by byte in the same order, and window writes are dropped. The filter reads the bank through its own independent port, which has one cycle of latency.

Any write to a configuration address returns the pointer and the byte count to zero. This gives the host a known starting point before every load or readback. Writing past the last entry wraps the pointer back to entry 0 and raises a sticky overflow flag.

Top module: `coef_cfg_port`

## Requirements
- R1: After reset the decoded outputs read as follows: halfband count 0, filter enable 0, read mode 0, decimation 8, tap count 256, symmetry 0, overflow 0. The read data output is 0.
- R2: Address 0 is the control register. Bits 2:0 drive the halfband count, bit 3 the filter enable, and bit 4 the coefficient read mode. Bits 7:5 drive the decimation rate, where code 000 decodes to 8 and any other code decodes to its own value.
- R3: Address 1 holds the tap count. The value 0 decodes to 256 and every other value decodes to itself.
- R4: Writes to reserved bits are ignored, and those bits read back as 0. Reserved bits are bits 7:2 of address 6 (symmetry code in bits 1:0), bit 7 of address 3 (input format), bits 7:6 of address 4 (output timing) and bit 7 of address 7 (mix format). Address 5 (output format) has no reserved bits.
- R5: A read strobe to a configuration address returns the stored byte on the read data output in the cycle after the strobe.
- R6: With read mode 0, each group of four writes to address 2 forms one 32-bit word, least significant byte first. The word is stored at the current pointer entry on the fourth write, and the pointer then advances by one. The filter read port returns entry contents one cycle after its address is applied.
- R7: With read mode 1, writes to address 2 change neither the coefficient bank nor the pointer or byte position.
- R8: With read mode 1, reads of address 2 return the bytes of the current entry least significant first, one cycle after each strobe, and the pointer advances after the fourth byte. With read mode 0, reads of address 2 return 0 and do not move the pointer or the byte position.
- R9: A write to any address other than 2 returns the pointer to entry 0 and the byte position to the first byte.
- R10: When a word is stored at the last entry, the pointer wraps to 0. The next stored word, which overwrites entry 0, sets the overflow output. That output stays set until reset.
- R11: A partly written word leaves the coefficient bank unchanged until its fourth byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| hb_count_o | output | 3 | Halfband stage count |
| filt_en_o | output | 1 | Filter enable |
| rd_mode_o | output | 1 | Coefficient read mode |
| fir_dec_o | output | 4 | Decoded decimation rate, 1 to 8 |
| tap_count_o | output | 9 | Decoded tap count, 1 to 256 |
| symmetry_o | output | 2 | Coefficient symmetry code |
| in_fmt_o | output | 7 | Input format byte, unreserved bits |
| out_tim_o | output | 6 | Output timing byte, unreserved bits |
| out_fmt_o | output | 8 | Output format byte |
| mix_fmt_o | output | 7 | Mix factor format byte, unreserved bits |
| ovf_o | output | 1 | Sticky coefficient overflow flag |
| filt_raddr_i | input | PTR_W | Filter-side coefficient address |
| filt_rdata_o | output | COEF_W | Filter-side coefficient word, one cycle latency |

## Verification
The bench builds the block with a 32-bit coefficient word and a depth of 8 entries instead of 128. At that depth the wrap and sticky overflow case takes only nine words, while the same four-byte assembly path is still exercised. The word width stays at its default, so the four-byte grouping, the byte order of the holding register and the readback byte selection are checked at their real size. The smaller depth also keeps the pointer-reset, gated-write and partial-word cases inside a short run.

// File: rtl/coef_cfg_pkg.sv
package coef_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_TAPS  = 3'd1,
    A_COEF  = 3'd2,
    A_INFMT = 3'd3,
    A_OTIM  = 3'd4,
    A_OFMT  = 3'd5,
    A_SYM   = 3'd6,
    A_MIX   = 3'd7
  } reg_addr_e;

  // writable bits per configuration address
  function automatic logic [BYTE_W-1:0] wr_mask(input logic [2:0] a);
    case (a)
      A_INFMT: wr_mask = 8'h7f;
      A_OTIM:  wr_mask = 8'h3f;
      A_SYM:   wr_mask = 8'h03;
      A_MIX:   wr_mask = 8'h7f;
      A_COEF:  wr_mask = 8'h00;
      default: wr_mask = 8'hff;
    endcase
  endfunction
endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
  import coef_cfg_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [2:0]                  addr_i,
  input  logic [BYTE_W-1:0]           wdata_i,
  output logic [7:0][BYTE_W-1:0]      regs_o
);
  for (genvar g = 0; g < 8; g++) begin : g_reg
    if (g == int'(A_COEF)) begin : g_hole
      assign regs_o[g] = '0;
    end else begin : g_store
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (wr_i && addr_i == 3'(g)) q <= wdata_i & wr_mask(3'(g));
      end
      assign regs_o[g] = q;
    end
  end
endmodule

// File: rtl/coef_seq.sv
module coef_seq
  import coef_cfg_pkg::*;
#(
  parameter int unsigned COEF_W     = 32,
  parameter int unsigned COEF_DEPTH = 128,
  localparam int unsigned NB    = COEF_W / BYTE_W,
  localparam int unsigned PTR_W = $clog2(COEF_DEPTH),
  localparam int unsigned BC_W  = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [2:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_mode_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BC_W-1:0]   bcnt_o,
  output logic              we_o,
  output logic [COEF_W-1:0] wword_o,
  output logic              ovf_o
);
  logic [PTR_W-1:0] ptr_q;
  logic [BC_W-1:0]  bcnt_q;
  logic [NB-2:0][BYTE_W-1:0] hold_q;
  logic full_q, ovf_q;

  logic hit, cwr, crd, clr, last, top;
  assign hit  = addr_i == A_COEF;
  assign cwr  = wr_i && hit && !rd_mode_i;
  assign crd  = rd_i && hit && rd_mode_i && !wr_i;
  assign clr  = wr_i && !hit;
  assign last = bcnt_q == BC_W'(NB - 1);
  assign top  = ptr_q == PTR_W'(COEF_DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      bcnt_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (clr) begin
      ptr_q  <= '0;
      bcnt_q <= '0;
      full_q <= 1'b0;
    end else if (cwr || crd) begin
      bcnt_q <= last ? '0 : bcnt_q + 1'b1;
      if (last) ptr_q <= top ? '0 : ptr_q + 1'b1;
      if (cwr && last) begin
        if (top)    full_q <= 1'b1;
        if (full_q) ovf_q  <= 1'b1;
      end
    end
  end

  // low bytes wait here; the final byte bypasses into the commit word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (cwr && !last) hold_q[bcnt_q] <= wdata_i;
  end

  assign ptr_o   = ptr_q;
  assign bcnt_o  = bcnt_q;
  assign we_o    = cwr && last;
  assign wword_o = {wdata_i, hold_q};
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/coef_ram.sv
module coef_ram #(
  parameter int unsigned COEF_W     = 32,
  parameter int unsigned COEF_DEPTH = 128,
  localparam int unsigned PTR_W = $clog2(COEF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [COEF_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  host_addr_i,
  output logic [COEF_W-1:0] host_word_o,
  input  logic [PTR_W-1:0]  filt_addr_i,
  output logic [COEF_W-1:0] filt_word_o
);
  logic [COEF_W-1:0] mem [COEF_DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) filt_word_o <= '0;
    else         filt_word_o <= mem[filt_addr_i];
  end

  assign host_word_o = mem[host_addr_i];
endmodule

// File: rtl/coef_cfg_port.sv
module coef_cfg_port
  import coef_cfg_pkg::*;
#(
  parameter int unsigned COEF_W     = 32,
  parameter int unsigned COEF_DEPTH = 128,
  localparam int unsigned NB    = COEF_W / BYTE_W,
  localparam int unsigned PTR_W = $clog2(COEF_DEPTH),
  localparam int unsigned BC_W  = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [7:0]        rdata_o,
  output logic [2:0]        hb_count_o,
  output logic              filt_en_o,
  output logic              rd_mode_o,
  output logic [3:0]        fir_dec_o,
  output logic [8:0]        tap_count_o,
  output logic [1:0]        symmetry_o,
  output logic [6:0]        in_fmt_o,
  output logic [5:0]        out_tim_o,
  output logic [7:0]        out_fmt_o,
  output logic [6:0]        mix_fmt_o,
  output logic              ovf_o,
  input  logic [PTR_W-1:0]  filt_raddr_i,
  output logic [COEF_W-1:0] filt_rdata_o
);
  logic [7:0][BYTE_W-1:0] regs;
  logic [PTR_W-1:0] ptr_q;
  logic [BC_W-1:0]  bcnt_q;
  logic             we;
  logic [COEF_W-1:0] wword;
  logic [NB-1:0][BYTE_W-1:0] host_bytes;
  logic rd_mode;

  cfg_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i,
    .regs_o (regs)
  );

  assign rd_mode = regs[A_CTRL][4];

  coef_seq #(.COEF_W(COEF_W), .COEF_DEPTH(COEF_DEPTH)) u_seq (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .rd_mode_i (rd_mode),
    .ptr_o     (ptr_q),
    .bcnt_o    (bcnt_q),
    .we_o      (we),
    .wword_o   (wword),
    .ovf_o     (ovf_o)
  );

  coef_ram #(.COEF_W(COEF_W), .COEF_DEPTH(COEF_DEPTH)) u_ram (
    .clk_i, .rst_ni,
    .we_i        (we),
    .waddr_i     (ptr_q),
    .wdata_i     (wword),
    .host_addr_i (ptr_q),
    .host_word_o (host_bytes),
    .filt_addr_i (filt_raddr_i),
    .filt_word_o (filt_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else if (rd_i) begin
      if (addr_i == A_COEF) rdata_o <= rd_mode ? host_bytes[bcnt_q] : '0;
      else                  rdata_o <= regs[addr_i];
    end
  end

  assign hb_count_o  = regs[A_CTRL][2:0];
  assign filt_en_o   = regs[A_CTRL][3];
  assign rd_mode_o   = rd_mode;
  assign fir_dec_o   = (regs[A_CTRL][7:5] == 3'd0) ? 4'd8 : {1'b0, regs[A_CTRL][7:5]};
  assign tap_count_o = (regs[A_TAPS] == 8'd0) ? 9'd256 : {1'b0, regs[A_TAPS]};
  assign symmetry_o  = regs[A_SYM][1:0];
  assign in_fmt_o    = regs[A_INFMT][6:0];
  assign out_tim_o   = regs[A_OTIM][5:0];
  assign out_fmt_o   = regs[A_OFMT];
  assign mix_fmt_o   = regs[A_MIX][6:0];
endmodule

// File: rtl/coef_cfg_port_chk.sv
module coef_cfg_port_chk #(
  parameter int unsigned PTR_W = 7,
  parameter int unsigned BC_W  = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             rd_i,
  input logic [2:0]       addr_i,
  input logic             rd_mode_i,
  input logic [PTR_W-1:0] ptr_i,
  input logic [BC_W-1:0]  bcnt_i,
  input logic             ovf_i,
  input logic [3:0]       fir_dec_i,
  input logic [8:0]       taps_i,
  input logic [7:0]       rdata_i
);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);

  // R9
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != 3'd2) |=> (ptr_i == '0 && bcnt_i == '0));

  // R7
  gated_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && addr_i == 3'd2 && rd_mode_i) |=> ($stable(ptr_i) && $stable(bcnt_i)));

  // R8
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == 3'd2 && !rd_mode_i) |=> ($stable(ptr_i) && $stable(bcnt_i) && rdata_i == 8'd0));

  // R2
  dec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fir_dec_i != 4'd0 && fir_dec_i <= 4'd8));

  // R3
  taps_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taps_i != 9'd0));

  // R4
  sym_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd6) |=> (rdata_i[7:2] == 6'd0));
endmodule

bind coef_cfg_port coef_cfg_port_chk #(.PTR_W(PTR_W), .BC_W(BC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .addr_i    (addr_i),
  .rd_mode_i (rd_mode),
  .ptr_i     (ptr_q),
  .bcnt_i    (bcnt_q),
  .ovf_i     (ovf_o),
  .fir_dec_i (fir_dec_o),
  .taps_i    (tap_count_o),
  .rdata_i   (rdata_o)
);

// File: tb/sim_coef_cfg_port.sv
module sim_coef_cfg_port;
  localparam int unsigned CW = 32;
  localparam int unsigned CD = 8;
  localparam int unsigned PW = $clog2(CD);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic [2:0] hb;
  logic fen, rmode, ovf;
  logic [3:0] dec;
  logic [8:0] taps;
  logic [1:0] sym;
  logic [6:0] infmt, mixfmt;
  logic [5:0] otim;
  logic [7:0] ofmt;
  logic [PW-1:0] fraddr = '0;
  logic [CW-1:0] frdata;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit rd_seen = 1'b0;
  logic [CW-1:0] model [CD];

  always #4 clk = ~clk;

  coef_cfg_port #(.COEF_W(CW), .COEF_DEPTH(CD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
    .hb_count_o(hb), .filt_en_o(fen), .rd_mode_o(rmode), .fir_dec_o(dec),
    .tap_count_o(taps), .symmetry_o(sym), .in_fmt_o(infmt), .out_tim_o(otim),
    .out_fmt_o(ofmt), .mix_fmt_o(mixfmt), .ovf_o(ovf),
    .filt_raddr_i(fraddr), .filt_rdata_o(frdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected byte per observed read strobe
  always @(posedge clk) rd_seen <= rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected read", 32'(rdata), 32'h0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata == e, t, 32'(rdata), 32'(e));
      end
    end
  end

  task automatic wr_b(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_b(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) wr_b(3'd2, w[k*8 +: 8]);
  endtask

  task automatic rd_word(input logic [31:0] w, input string t);
    for (int k = 0; k < 4; k++) rd_b(3'd2, w[k*8 +: 8], t);
  endtask

  task automatic fchk(input int idx, input logic [31:0] e, input string t);
    @(negedge clk); fraddr = PW'(idx);
    @(negedge clk); chk(frdata == e, t, frdata, e);
  endtask

  function automatic logic [31:0] wgen(input int i);
    return 32'(i) * 32'h9E3779B1 + 32'h00C0FFEE;
  endfunction

  task automatic finish_run();
    @(negedge clk); @(negedge clk);
    chk(exp_q.size() == 0, "R5 pending reads", 32'(exp_q.size()), 32'h0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hb == 0 && fen == 0 && rmode == 0, "R1 ctrl fields", {hb, fen, rmode}, 0);
    chk(dec == 4'd8, "R1 decimation", dec, 8);
    chk(taps == 9'd256, "R1 taps", taps, 256);
    chk(sym == 0 && ovf == 0 && rdata == 0, "R1 sym/ovf/rdata", {sym, ovf, rdata}, 0);

    // R2 control decode
    wr_b(3'd0, 8'hAB);
    chk(hb == 3'd3 && fen && !rmode, "R2 hb/en/mode", {hb, fen, rmode}, {3'd3, 1'b1, 1'b0});
    chk(dec == 4'd5, "R2 decimation", dec, 5);
    rd_b(3'd0, 8'hAB, "R5 ctrl readback");
    wr_b(3'd0, 8'h1F);
    chk(dec == 4'd8 && hb == 3'd7 && rmode, "R2 code 000 and mode", {dec, hb, rmode}, {4'd8, 3'd7, 1'b1});

    // R3 tap count
    wr_b(3'd1, 8'h00);
    chk(taps == 9'd256, "R3 zero is 256", taps, 256);
    wr_b(3'd1, 8'h40);
    chk(taps == 9'd64, "R3 value", taps, 64);
    rd_b(3'd1, 8'h40, "R5 taps readback");

    // R4 reserved bits
    wr_b(3'd6, 8'hFE);
    chk(sym == 2'd2, "R4 symmetry", sym, 2);
    rd_b(3'd6, 8'h02, "R4 sym readback");
    wr_b(3'd3, 8'hFF); rd_b(3'd3, 8'h7F, "R4 infmt readback");
    wr_b(3'd4, 8'hFF); rd_b(3'd4, 8'h3F, "R4 otim readback");
    wr_b(3'd7, 8'hFF); rd_b(3'd7, 8'h7F, "R4 mix readback");
    wr_b(3'd5, 8'hC9); rd_b(3'd5, 8'hC9, "R5 ofmt readback");
    chk(infmt == 7'h7F && otim == 6'h3F && mixfmt == 7'h7F && ofmt == 8'hC9,
        "R4 format outputs", {infmt, otim, mixfmt, ofmt}, {7'h7F, 6'h3F, 7'h7F, 8'hC9});

    // R6 assembly and auto increment
    wr_b(3'd0, 8'h0B);
    for (int i = 0; i < 3; i++) begin
      model[i] = wgen(i); wr_word(model[i]);
    end
    for (int i = 0; i < 3; i++) fchk(i, model[i], "R6 stored word");

    // R11 partial word holds off the bank
    wr_b(3'd0, 8'h0B);
    for (int k = 0; k < 3; k++) wr_b(3'd2, wgen(3)[k*8 +: 8]);
    fchk(0, model[0], "R11 partial word");
    wr_b(3'd2, wgen(3)[31:24]);
    model[0] = wgen(3);
    fchk(0, model[0], "R11 word complete");

    // R9 mid-word config write clears pointer and byte position
    wr_b(3'd2, 8'h11); wr_b(3'd2, 8'h22);
    wr_b(3'd1, 8'h40);
    model[0] = wgen(4); wr_word(model[0]);
    fchk(0, model[0], "R9 restart at entry 0");
    model[1] = wgen(5); wr_word(model[1]);
    fchk(1, model[1], "R9 next entry");

    // R8 readback in read mode
    wr_b(3'd0, 8'h1B);
    rd_word(model[0], "R8 entry 0 bytes");
    rd_word(model[1], "R8 entry 1 bytes");
    // R7 writes ignored in read mode
    wr_word(32'hDEADBEEF);
    fchk(2, model[2], "R7 bank unchanged");
    rd_word(model[2], "R7 pointer unchanged");

    // R8 window read in write mode returns 0 and does not advance
    wr_b(3'd0, 8'h0B);
    rd_b(3'd2, 8'h00, "R8 write-mode read");
    rd_b(3'd2, 8'h00, "R8 write-mode read");
    model[0] = wgen(6); wr_word(model[0]);
    fchk(0, model[0], "R8 no advance");

    // R10 wrap and sticky overflow
    wr_b(3'd0, 8'h0B);
    for (int i = 0; i < CD; i++) begin
      model[i] = wgen(10 + i); wr_word(model[i]);
    end
    chk(ovf == 1'b0, "R10 full bank no overflow", ovf, 0);
    fchk(CD - 1, model[CD-1], "R10 last entry");
    model[0] = wgen(40); wr_word(model[0]);
    chk(ovf == 1'b1, "R10 overflow set", ovf, 1);
    fchk(0, model[0], "R10 wrapped to entry 0");
    fchk(1, model[1], "R10 entry 1 kept");
    wr_b(3'd1, 8'h10);
    chk(ovf == 1'b1, "R10 overflow sticky", ovf, 1);

    finish_run();
  end
endmodule